// File: doc/BRIEF.md
# Byte/Word Integer ALU with Flags

This block is the integer execution unit of a small processor datapath. Each issued operation brings a destination operand, a source operand, the incoming carry and auxiliary-carry flags, a width select and a 4-bit operation code. One clock later the block presents the result, a write-enable that says whether the result belongs in the destination, and the six status flags: carry, auxiliary carry, overflow, sign, zero and parity.

The block covers addition and subtraction with and without an incoming carry, increment, decrement, two's-complement negate, compare, the bitwise operations (AND, OR, XOR, TEST and NOT), and the two packed-BCD corrections that run after an add or a subtract. Each operation has its own rule for which flags it updates. Flags that an operation leaves alone are handled in one of two ways. CF and AF pass through from their inputs. OF, SF, ZF and PF keep their registered values.

Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 INC, 5 DEC, 6 NEG, 7 CMP, 8 AND, 9 OR, 10 XOR, 11 TEST, 12 NOT, 13 BCD adjust after add, 14 BCD adjust after subtract, 15 reserved. The `wide` input selects word width when it is 1 and byte width when it is 0. In byte mode only bits 7:0 of the operands are used.

Top module: `alu_bw`

## Requirements
- R1: When `in_valid` is 1 on a clock edge, the outputs computed from that operation appear after that edge and `out_valid` is 1 for exactly that one cycle. Without `in_valid`, `out_valid` is 0 and the other outputs hold. Reset clears every output to 0.
- R2: ADD (0), ADC (1), SUB (2) and SBB (3) compute dst+src, dst+src+cf_in, dst-src and dst-src-cf_in at the selected width. CF is the carry out of the top bit, or the borrow for the subtracting codes. `wr_en` is 1.
- R3: For every arithmetic code, AF is the carry out of bit 3, or the borrow into it for the subtracting codes. OF is 1 when the signed result does not fit the selected width.
- R4: INC (4) and DEC (5) add or subtract 1 and update AF, OF, SF, ZF and PF, while CF equals cf_in. A byte FF or a word FFFF incremented gives 0.
- R5: NEG (6) gives 0 minus dst. CF is 1 unless the operand is zero, and OF is 1 only for the most negative value (80h or 8000h).
- R6: CMP (7) sets every flag as SUB would and TEST (11) sets flags as AND would. Both drive `wr_en` to 0.
- R7: AND (8), OR (9), XOR (10) and TEST force CF, OF and AF to 0.
- R8: NOT (12) gives the bitwise complement with `wr_en`=1. CF and AF equal cf_in and af_in, and OF, SF, ZF and PF keep their previous output values. Reserved code 15 behaves the same except that the result is dst itself and `wr_en` is 0.
- R9: In every code that updates them, SF is the top bit of the result at the selected width, ZF is 1 when the result is zero, and PF is 1 when bits 7:0 of the result hold an even number of ones, at either width. In byte mode, result bits 15:8 are 0.
- R10: BCD adjust after add (13) works on dst[7:0] regardless of width. If the low nibble is above 9 or af_in is 1, it adds 6 and sets AF, otherwise AF is 0. It then adds 60h and sets CF when the new high nibble is above 9, when cf_in is 1 or when the first step carried out; otherwise CF is 0. OF is 0, SF is bit 7, and result[15:8] is 0.
- R11: BCD adjust after subtract (14) follows the same rules with 6 and 60h subtracted, and a borrow from the first step counts as the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| wide | input | 1 | 1 = word, 0 = byte |
| op | input | 4 | Operation code |
| dst | input | 16 | Destination operand |
| src | input | 16 | Source operand |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Result is to be written back |
| cf | output | 1 | Carry flag |
| af | output | 1 | Auxiliary-carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |

## Verification
The checker watches several properties on every issued operation. It checks the one-cycle valid pipeline, the zero upper byte in byte mode, the agreement of ZF and PF with the result, the forced-zero CF, OF and AF after logic codes, the pass-through carry of INC and DEC, the suppressed write of CMP and TEST, and the held OF, SF, ZF and PF after NOT. The checker cannot see the arithmetic values themselves. Correct sums and differences, AF and OF at both widths, the negate corner values and the two BCD corrections can only be shown by the bench, which runs seeded random operations and directed boundary cases against its own reference model.

// File: rtl/alu_bw.sv
module alu_bw (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        wide,
  input  logic [3:0]  op,
  input  logic [15:0] dst,
  input  logic [15:0] src,
  input  logic        cf_in,
  input  logic        af_in,
  output logic        out_valid,
  output logic [15:0] result,
  output logic        wr_en,
  output logic        cf,
  output logic        af,
  output logic        of,
  output logic        sf,
  output logic        zf,
  output logic        pf
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3;
  localparam logic [3:0] OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_NEG = 4'd6,  OP_CMP = 4'd7;
  localparam logic [3:0] OP_AND = 4'd8,  OP_OR  = 4'd9,  OP_XOR = 4'd10, OP_TST = 4'd11;
  localparam logic [3:0] OP_NOT = 4'd12, OP_DAA = 4'd13, OP_DAS = 4'd14;

  logic [15:0] am, bm, x, y, hx, res;
  logic [16:0] s17;
  logic        ci, sub, carry, xs, ys, rs, ovf;
  logic        nc, na, no, ns, nz, np, upd, wr;

  assign am = wide ? dst : {8'h00, dst[7:0]};
  assign bm = wide ? src : {8'h00, src[7:0]};

  always_comb begin
    x = am; y = bm; ci = 1'b0; sub = 1'b0;
    case (op)
      OP_ADC: ci = cf_in;
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_SBB: begin sub = 1'b1; ci = cf_in; end
      OP_INC: y = 16'd1;
      OP_DEC: begin sub = 1'b1; y = 16'd1; end
      OP_NEG: begin sub = 1'b1; x = 16'd0; y = am; end
      default: ;
    endcase
  end

  assign s17   = sub ? ({1'b0, x} - {1'b0, y} - {16'd0, ci})
                     : ({1'b0, x} + {1'b0, y} + {16'd0, ci});
  assign carry = wide ? s17[16] : s17[8];
  assign hx    = x ^ y ^ s17[15:0];
  assign xs    = wide ? x[15] : x[7];
  assign ys    = wide ? y[15] : y[7];
  assign rs    = wide ? s17[15] : s17[7];
  assign ovf   = sub ? ((xs != ys) && (rs != xs)) : ((xs == ys) && (rs != xs));

  logic       lofix, dahi, dshi;
  logic [8:0] da1, ds1;
  logic [7:0] da2, ds2;
  assign lofix = (dst[3:0] > 4'd9) || af_in;
  assign da1   = {1'b0, dst[7:0]} + (lofix ? 9'd6 : 9'd0);
  assign ds1   = {1'b0, dst[7:0]} - (lofix ? 9'd6 : 9'd0);
  assign dahi  = (da1[7:4] > 4'd9) || cf_in || da1[8];
  assign dshi  = (ds1[7:4] > 4'd9) || cf_in || ds1[8];
  assign da2   = da1[7:0] + (dahi ? 8'h60 : 8'h00);
  assign ds2   = ds1[7:0] - (dshi ? 8'h60 : 8'h00);

  always_comb begin
    res = wide ? s17[15:0] : {8'h00, s17[7:0]};
    nc = carry; na = hx[4]; no = ovf; upd = 1'b1; wr = 1'b1;
    case (op)
      OP_INC, OP_DEC: nc = cf_in;
      OP_CMP: wr = 1'b0;
      OP_AND, OP_TST: begin res = am & bm; nc = 1'b0; na = 1'b0; no = 1'b0; wr = (op == OP_AND); end
      OP_OR:  begin res = am | bm; nc = 1'b0; na = 1'b0; no = 1'b0; end
      OP_XOR: begin res = am ^ bm; nc = 1'b0; na = 1'b0; no = 1'b0; end
      OP_NOT: begin res = ~am & (wide ? 16'hFFFF : 16'h00FF); nc = cf_in; na = af_in; upd = 1'b0; end
      OP_DAA: begin res = {8'h00, da2}; nc = dahi; na = lofix; no = 1'b0; end
      OP_DAS: begin res = {8'h00, ds2}; nc = dshi; na = lofix; no = 1'b0; end
      4'd15:  begin res = am; nc = cf_in; na = af_in; upd = 1'b0; wr = 1'b0; end
      default: ;
    endcase
  end

  assign ns = (wide && op != OP_DAA && op != OP_DAS) ? res[15] : res[7];
  assign nz = (res == 16'd0);
  assign np = ~^res[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; result <= 16'd0; wr_en <= 1'b0;
      cf <= 1'b0; af <= 1'b0; of <= 1'b0; sf <= 1'b0; zf <= 1'b0; pf <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res; wr_en <= wr; cf <= nc; af <= na;
        if (upd) begin
          of <= no; sf <= ns; zf <= nz; pf <= np;
        end
      end
    end
  end
endmodule

// File: rtl/alu_bw_chk.sv
module alu_bw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        wide,
  input logic [3:0]  op,
  input logic        cf_in,
  input logic        out_valid,
  input logic [15:0] result,
  input logic        wr_en,
  input logic        cf,
  input logic        af,
  input logic        of,
  input logic        sf,
  input logic        zf,
  input logic        pf
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_inc_dec_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd4 || op == 4'd5)) |=> (cf == $past(cf_in)));
  assert_cmp_test_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd7 || op == 4'd11)) |=> !wr_en);
  assert_logic_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd8 && op <= 4'd11) |=> (!cf && !of && !af));
  assert_not_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd12) |=> $stable({of, sf, zf, pf}));
  assert_zero_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 4'd12 && op != 4'd15) |=> ((zf == (result == 16'd0)) && (pf == ~^result[7:0])));
  assert_byte_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[15:8] == 8'h00));
endmodule

bind alu_bw alu_bw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .op(op), .cf_in(cf_in),
  .out_valid(out_valid), .result(result), .wr_en(wr_en), .cf(cf), .af(af),
  .of(of), .sf(sf), .zf(zf), .pf(pf)
);

// File: tb/tb_alu_bw.sv
module tb_alu_bw;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, wide = 1'b0, cf_in = 1'b0, af_in = 1'b0;
  logic [3:0] op = 4'd0;
  logic [15:0] dst = 16'd0, src = 16'd0;
  logic out_valid, wr_en, cf, af, of, sf, zf, pf;
  logic [15:0] result;
  int errors = 0, checks = 0;
  logic m_of = 0, m_sf = 0, m_zf = 0, m_pf = 0;

  always #2 clk = ~clk;

  alu_bw dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .op(op),
    .dst(dst), .src(src), .cf_in(cf_in), .af_in(af_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .cf(cf), .af(af), .of(of), .sf(sf), .zf(zf), .pf(pf));

  function automatic string req_of(input logic [3:0] o);
    case (o)
      0, 1, 2, 3: return "R2/R3";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      8, 9, 10, 11: return "R7";
      12, 15: return "R8";
      13: return "R10";
      14: return "R11";
      default: return "R9";
    endcase
  endfunction

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic logic [22:0] model(input logic [3:0] o, input logic wd, input logic [15:0] d,
      input logic [15:0] s, input logic ci, input logic ai);
    int w, mask, a, b, c, t, st, r, al;
    logic e_cf, e_af, e_of, e_wr, upd, lof, c1;
    w = wd ? 16 : 8; mask = (1 << w) - 1;
    a = int'(d) & mask; b = int'(s) & mask; c = 0;
    e_wr = 1; upd = 1; e_af = 0; e_of = 0; e_cf = 0; r = 0;
    case (o)
      0, 1, 4: begin
        if (o == 4) b = 1; if (o == 1) c = int'(ci);
        t = a + b + c; r = t & mask; e_cf = (o == 4) ? ci : (t > mask);
        e_af = ((a & 15) + (b & 15) + c) > 15;
        st = sx(a, w) + sx(b, w) + c; e_of = (st > (1 << (w-1)) - 1) || (st < -(1 << (w-1)));
      end
      2, 3, 5, 6, 7: begin
        if (o == 5) b = 1; if (o == 3) c = int'(ci);
        if (o == 6) begin b = a; a = 0; end
        t = a - b - c; r = t & mask; e_cf = (o == 5) ? ci : (t < 0);
        e_af = ((a & 15) - (b & 15) - c) < 0;
        st = sx(a, w) - sx(b, w) - c; e_of = (st > (1 << (w-1)) - 1) || (st < -(1 << (w-1)));
        if (o == 7) e_wr = 0;
      end
      8, 11: begin r = a & b; if (o == 11) e_wr = 0; end
      9: r = a | b;
      10: r = a ^ b;
      12: begin r = (~a) & mask; e_cf = ci; e_af = ai; upd = 0; end
      15: begin r = a; e_cf = ci; e_af = ai; upd = 0; e_wr = 0; end
      default: begin
        w = 8; al = int'(d[7:0]); lof = ((al & 15) > 9) || ai; c1 = ci;
        if (lof) begin
          al = (o == 13) ? al + 6 : al - 6;
          if (al > 255 || al < 0) c1 = 1;
          al = al & 255; e_af = 1;
        end
        if ((al >> 4) > 9 || c1) begin
          al = ((o == 13) ? al + 'h60 : al - 'h60) & 255; e_cf = 1;
        end
        r = al;
      end
    endcase
    if (upd) begin
      m_of = e_of; m_sf = r[w-1]; m_zf = (r == 0); m_pf = ~^r[7:0];
    end
    return {1'b1, e_wr, r[15:0], e_cf, e_af, m_of, m_sf, m_zf};
  endfunction

  task automatic run_op(input logic [3:0] o, input logic wd, input logic [15:0] d,
      input logic [15:0] s, input logic ci, input logic ai);
    logic [22:0] exp_v, act_v;
    logic e_pf;
    @(negedge clk);
    op = o; wide = wd; dst = d; src = s; cf_in = ci; af_in = ai; in_valid = 1'b1;
    exp_v = model(o, wd, d, s, ci, ai); e_pf = m_pf;
    @(negedge clk);
    in_valid = 1'b0;
    act_v = {out_valid, wr_en, result, cf, af, of, sf, zf};
    checks++;
    if (act_v !== exp_v || pf !== e_pf) begin
      errors++;
      $display("FAIL %s op=%0d wide=%0b dst=%h src=%h: actual %h pf=%0b expected %h pf=%0b",
               req_of(o), o, wd, d, s, act_v, pf, exp_v, e_pf);
    end
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, wr_en, result, cf, af, of, sf, zf, pf} !== 24'd0) begin
      errors++;
      $display("FAIL R1 reset: actual %h expected 0", {out_valid, wr_en, result, cf, af, of, sf, zf, pf});
    end
    rst_n = 1'b1;
    run_op(4, 0, 16'h00FF, 0, 1, 0);          // R4 byte wrap, carry kept 1
    run_op(4, 1, 16'hFFFF, 0, 0, 0);          // R4 word wrap, carry kept 0
    run_op(5, 0, 16'h0000, 0, 1, 0);          // R4 decrement below zero
    run_op(6, 0, 16'h0080, 0, 0, 0);          // R5 most negative byte
    run_op(6, 1, 16'h0000, 0, 1, 0);          // R5 zero operand
    run_op(6, 1, 16'h8000, 0, 0, 0);          // R5 most negative word
    run_op(7, 1, 16'h1234, 16'h1234, 0, 0);   // R6 equal
    run_op(7, 0, 16'h0005, 16'h0009, 0, 0);   // R6 below
    run_op(11, 0, 16'h00F0, 16'h000F, 1, 1);  // R6 TEST zero
    run_op(1, 1, 16'hFFFF, 16'h0000, 1, 0);   // R2 carry in ripples out
    run_op(3, 1, 16'h8000, 16'h0000, 1, 0);   // R3 signed overflow on borrow
    run_op(0, 0, 16'h0078, 16'h0008, 0, 0);   // R3 aux carry and overflow
    run_op(10, 0, 16'h1281, 16'h3401, 1, 1);  // R9 byte mode upper zero
    run_op(12, 1, 16'h00FF, 0, 1, 0);         // R8 NOT holds flags
    run_op(15, 0, 16'h55AA, 0, 0, 1);         // R8 reserved code
    run_op(13, 1, 16'h009A, 0, 0, 0);         // R10 both corrections
    run_op(13, 0, 16'h0045, 0, 0, 1);         // R10 AF forces low fix
    run_op(13, 0, 16'h0012, 0, 1, 0);         // R10 CF forces high fix
    run_op(14, 0, 16'h00FA, 0, 0, 0);         // R11 both corrections
    run_op(14, 0, 16'h0003, 0, 0, 1);         // R11 low borrow
    for (int i = 0; i < 600; i++)
      run_op(4'($urandom_range(0, 15)), 1'($urandom), 16'($urandom), 16'($urandom),
             1'($urandom), 1'($urandom));
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle valid: actual %0b expected 0", out_valid);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule